// File: doc/BRIEF.md
# Adaptive Link Supervisor with Backoff

This block watches a point-to-point Ethernet PHY link that cannot be trusted to report a link coming up on its own. It counts millisecond ticks and raises a sample strobe at the end of each poll interval. At that strobe it reads a link-status input. If the link is up, polling continues at a relaxed link-up rate. If the link is down, the block pulses a PHY reset request. It then holds a recovery wait whose length depends on the local master or slave role, so that two identical partners do not stay locked into resetting together. When the wait ends, polling restarts from a fresh count.

While the link stays down, the block polls quickly at first. Once the outage has lasted long enough, it falls back to a slow rate. The outage age starts at the first down sample after reset or after an up sample. Every interval and wait length is a parameter counted in ticks. Cycles without a tick never advance any count.

Top module: `link_watch`

## Requirements
- R1: While reset is held, sample_stb, reset_req and recov_busy are 0 and poll_ival reads the fast down interval (149). The first strobe comes on the 149th tick after reset is released.
- R2: A strobe that sees link_up=1 raises no reset request. The next strobe comes exactly 421 ticks later, and poll_ival reads 421.
- R3: A strobe that sees link_up=0 drives reset_req high for exactly that one cycle, and recov_busy rises in the same cycle.
- R4: The recovery wait lasts 97 ticks when is_slave=0 and 149 ticks when is_slave=1. The role is taken at the down strobe, so later changes to is_slave do not alter a wait already running. No strobe is issued while recov_busy is high.
- R5: After recov_busy falls, the next strobe comes exactly poll_ival ticks later. The poll count restarts from zero when the wait ends.
- R6: The outage age counts the ticks after the first down strobe. At the tick that ends a wait, if that age (not counting this tick) is at least 6000, the next interval is 1117. Otherwise it is 149.
- R7: Later down strobes do not restart the outage age. An up strobe clears it, so the first wait after the next loss is followed by the 149 interval again.
- R8: An interval or wait parameter set to 0 acts as 1 tick.
- R9: Intervals and waits are measured in ticks (cycles with tick_ms=1), not in clock cycles.
- R10: poll_ival shows the interval that governs the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond tick |
| link_up | input | 1 | Link status from the PHY, read at each strobe |
| is_slave | input | 1 | Role: 1 selects the slave wait, 0 the master wait |
| reset_req | output | 1 | One-cycle PHY reset request |
| sample_stb | output | 1 | One-cycle strobe marking a link-status read |
| recov_busy | output | 1 | High during the post-reset recovery wait |
| poll_ival | output | IVAL_W | Poll interval currently in force, in ticks |

## Verification
The hardest situation to reach is the switch from fast to slow polling. Whether it happens depends on how the outage age stands at the exact tick a recovery wait ends, and only a long, unbroken run of down samples builds that age. The bench holds the link down from reset in the master role. The grid of waits and fast intervals then puts the end of the 25th wait exactly on the 6000-tick age. The bench computes every gap from the rule in R6 and checks each one, including the first slow gap. It then brings the link up for one sample to show that the age is cleared.

// File: rtl/lw_pkg.sv
package lw_pkg;

  typedef enum logic {
    LW_POLL,
    LW_RECOV
  } lw_phase_e;

  // Zero-valued timing parameters collapse to a single tick
  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/lw_span_cnt.sv
module lw_span_cnt #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt;

  assign hit = en && tick && (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && tick) begin
      cnt <= hit ? '0 : cnt + W'(1);
    end
  end

  // R8
  span_limit_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (limit != '0));

  // R5
  span_range_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < limit));

endmodule

// File: rtl/lw_down_age.sv
module lw_down_age #(
  parameter int LIMIT = 6000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  input  logic clear,
  output logic active,
  output logic aged
);

  localparam int AW = $clog2(LIMIT + 1);
  localparam logic [AW-1:0] LIM = AW'(LIMIT);

  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      active <= 1'b0;
      age    <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      age    <= '0;
    end else if (active && tick && (age != LIM)) begin
      age <= age + AW'(1);
    end
  end

  assign aged = active && (age >= LIM);

  // R7
  age_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> !active);

  // R6
  age_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(aged) |-> $past(tick));

endmodule

// File: rtl/link_watch.sv
module link_watch
  import lw_pkg::*;
#(
  parameter int IVAL_W         = 11,
  parameter int UP_MS          = 421,
  parameter int FAST_MS        = 149,
  parameter int FAST_SPAN_MS   = 6000,
  parameter int SLOW_MS        = 1117,
  parameter int WAIT_MASTER_MS = 97,
  parameter int WAIT_SLAVE_MS  = 149
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ms,
  input  logic              link_up,
  input  logic              is_slave,
  output logic              reset_req,
  output logic              sample_stb,
  output logic              recov_busy,
  output logic [IVAL_W-1:0] poll_ival
);

  localparam logic [IVAL_W-1:0] UP_T   = IVAL_W'(at_least_one(UP_MS));
  localparam logic [IVAL_W-1:0] FAST_T = IVAL_W'(at_least_one(FAST_MS));
  localparam logic [IVAL_W-1:0] SLOW_T = IVAL_W'(at_least_one(SLOW_MS));
  localparam logic [IVAL_W-1:0] WM_T   = IVAL_W'(at_least_one(WAIT_MASTER_MS));
  localparam logic [IVAL_W-1:0] WS_T   = IVAL_W'(at_least_one(WAIT_SLAVE_MS));

  lw_phase_e         phase;
  logic [IVAL_W-1:0] ival_q;
  logic [IVAL_W-1:0] wait_q;
  logic              stb_q, rreq_q, busy_q;
  logic              poll_hit, wait_hit;
  logic              age_active, age_done;

  lw_span_cnt #(.W(IVAL_W)) u_poll (
    .clk   (clk),
    .rst   (rst),
    .en    (phase == LW_POLL),
    .clr   (phase == LW_RECOV),
    .tick  (tick_ms),
    .limit (ival_q),
    .hit   (poll_hit)
  );

  lw_span_cnt #(.W(IVAL_W)) u_wait (
    .clk   (clk),
    .rst   (rst),
    .en    (phase == LW_RECOV),
    .clr   (phase == LW_POLL),
    .tick  (tick_ms),
    .limit (wait_q),
    .hit   (wait_hit)
  );

  lw_down_age #(.LIMIT(FAST_SPAN_MS)) u_age (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_ms),
    .start  (poll_hit && !link_up),
    .clear  (poll_hit && link_up),
    .active (age_active),
    .aged   (age_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= LW_POLL;
      ival_q <= FAST_T;
      wait_q <= WM_T;
      stb_q  <= 1'b0;
      rreq_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      stb_q  <= poll_hit;
      rreq_q <= 1'b0;
      unique case (phase)
        LW_POLL: begin
          if (poll_hit) begin
            if (link_up) begin
              ival_q <= UP_T;
            end else begin
              rreq_q <= 1'b1;
              busy_q <= 1'b1;
              phase  <= LW_RECOV;
              wait_q <= is_slave ? WS_T : WM_T;
            end
          end
        end
        LW_RECOV: begin
          if (wait_hit) begin
            busy_q <= 1'b0;
            phase  <= LW_POLL;
            ival_q <= age_done ? SLOW_T : FAST_T;
          end
        end
        default: phase <= LW_POLL;
      endcase
    end
  end

  assign sample_stb = stb_q;
  assign reset_req  = rreq_q;
  assign recov_busy = busy_q;
  assign poll_ival  = ival_q;

  // R3
  reset_at_sample_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> (sample_stb && recov_busy));

  // R3
  reset_single_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(recov_busy) |-> reset_req);

  // R4
  no_sample_in_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (recov_busy && $past(recov_busy)) |-> !sample_stb);

  // R9
  wait_ends_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(recov_busy) |-> $past(tick_ms));

  // R8
  ival_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    poll_ival != '0);

  // R7
  age_held_chk: assert property (@(posedge clk) disable iff (rst)
    recov_busy |-> age_active);

endmodule

// File: tb/sim_link_watch.sv
module sim_link_watch;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;

  // row: link, slave, expect reset, wait ticks[7:0], interval after[10:0]
  localparam logic [21:0] TBL [0:5] = '{
    {1'b1, 1'b0, 1'b0, 8'd0,   11'd421},
    {1'b1, 1'b0, 1'b0, 8'd0,   11'd421},
    {1'b0, 1'b0, 1'b1, 8'd97,  11'd149},
    {1'b0, 1'b1, 1'b1, 8'd149, 11'd149},
    {1'b1, 1'b1, 1'b0, 8'd0,   11'd421},
    {1'b0, 1'b1, 1'b1, 8'd149, 11'd149}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic alt_mode = 1'b0;
  logic alt_ph = 1'b0;
  logic link_up = 1'b0;
  logic is_slave = 1'b0;
  logic tick_ms;

  logic        reset_req, sample_stb, recov_busy;
  logic [10:0] poll_ival;
  logic        u1_rreq, u1_stb, u1_busy;
  logic [10:0] u1_ival;

  int checks = 0;
  int errs = 0;
  int tk = 0;
  int cyc = 0;
  int overlap = 0;
  int u1_prev = 0;
  int u1_seen = 0;
  int u1_bad = 0;

  assign tick_ms = tick_en & (~alt_mode | alt_ph);

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) tk <= 0;
    else if (tick_ms) tk <= tk + 1;
  end

  always @(negedge clk) alt_ph <= ~alt_ph;

  always @(negedge clk) begin
    if (!rst && sample_stb && recov_busy && !reset_req) overlap++;
    if (rst) u1_prev = 0;
    else if (u1_stb) begin
      if (u1_prev != 0) begin
        u1_seen++;
        if (tk - u1_prev != 2) u1_bad++;
      end
      u1_prev = tk;
    end
  end

  link_watch u0 (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .link_up(link_up),
    .is_slave(is_slave), .reset_req(reset_req), .sample_stb(sample_stb),
    .recov_busy(recov_busy), .poll_ival(poll_ival)
  );

  link_watch #(
    .FAST_MS(0), .SLOW_MS(0), .WAIT_MASTER_MS(0), .WAIT_SLAVE_MS(0)
  ) u1 (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .link_up(1'b0),
    .is_slave(1'b0), .reset_req(u1_rreq), .sample_stb(u1_stb),
    .recov_busy(u1_busy), .poll_ival(u1_ival)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_stb(output int t);
    @(negedge clk);
    while (!sample_stb && cyc < WD_LIMIT) @(negedge clk);
    t = tk;
  endtask

  task automatic wait_idle();
    while (recov_busy && cyc < WD_LIMIT) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick_en = 1'b1;
  endtask

  initial begin
    int t, prev, t1, s, c5, c6, exp_gap;
    logic [21:0] row;

    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk(sample_stb == 1'b0, "R1 strobe in reset", sample_stb, 0);
    chk(reset_req == 1'b0, "R1 reset_req in reset", reset_req, 0);
    chk(recov_busy == 1'b0, "R1 busy in reset", recov_busy, 0);
    chk(poll_ival == 11'd149, "R1 interval in reset", poll_ival, 149);

    // Table walk: R2, R3, R4, R5, R10
    row = TBL[0];
    link_up = row[21];
    is_slave = row[20];
    rst = 1'b0;
    tick_en = 1'b1;
    prev = 0;
    for (int i = 0; i < 6; i++) begin
      wait_stb(t);
      if (i == 0) chk(t == 149, "R1 first strobe tick", t, 149);
      else begin
        row = TBL[i-1];
        exp_gap = int'(row[18:11]) + int'(row[10:0]);
        chk(t - prev == exp_gap, "R5 strobe gap", t - prev, exp_gap);
      end
      prev = t;
      row = TBL[i];
      chk(reset_req == row[19], "R3 reset at strobe", reset_req, row[19]);
      if (row[19]) begin
        chk(recov_busy == 1'b1, "R3 busy with reset", recov_busy, 1);
        if (i + 1 < 6) begin
          link_up = TBL[i+1][21];
          is_slave = TBL[i+1][20];
        end
        s = t;
        @(negedge clk);
        chk(reset_req == 1'b0, "R3 reset one cycle", reset_req, 0);
        wait_idle();
        chk(tk - s == int'(row[18:11]), "R4 wait length", tk - s, int'(row[18:11]));
      end else if (i + 1 < 6) begin
        link_up = TBL[i+1][21];
        is_slave = TBL[i+1][20];
      end
      chk(poll_ival == row[10:0], "R10 interval after sample", poll_ival, row[10:0]);
    end
    link_up = 1'b1;
    wait_stb(t);
    row = TBL[5];
    exp_gap = int'(row[18:11]) + int'(row[10:0]);
    chk(t - prev == exp_gap, "R5 last gap", t - prev, exp_gap);

    // R6: long outage as master, gaps from the age rule
    do_reset();
    link_up = 1'b0;
    is_slave = 1'b0;
    wait_stb(t1);
    chk(t1 == 149, "R1 first strobe after reset", t1, 149);
    prev = t1;
    for (int n = 1; n <= 26; n++) begin
      wait_stb(t);
      exp_gap = 97 + (((prev + 97 - t1 - 1) >= 6000) ? 1117 : 149);
      chk(t - prev == exp_gap, "R6 outage gap", t - prev, exp_gap);
      prev = t;
    end
    chk(poll_ival == 11'd1117, "R6 slow interval", poll_ival, 1117);

    // R7: an up sample clears the age, next loss returns to fast
    link_up = 1'b1;
    wait_stb(t);
    chk(t - prev == 1214, "R6 slow gap before up", t - prev, 1214);
    chk(reset_req == 1'b0, "R2 no reset on up", reset_req, 0);
    link_up = 1'b0;
    prev = t;
    wait_stb(t);
    chk(t - prev == 421, "R2 up interval", t - prev, 421);
    chk(reset_req == 1'b1, "R3 reset on loss", reset_req, 1);
    wait_idle();
    chk(poll_ival == 11'd149, "R7 fast after fresh loss", poll_ival, 149);
    prev = t;
    wait_stb(t);
    chk(t - prev == 246, "R7 fast gap after loss", t - prev, 246);

    // R9: ticks on every other cycle
    link_up = 1'b1;
    wait_stb(t);
    alt_mode = 1'b1;
    wait_stb(t);
    prev = t;
    c5 = cyc;
    wait_stb(t);
    c6 = cyc;
    chk(t - prev == 421, "R9 tick gap", t - prev, 421);
    chk(c6 - c5 == 842, "R9 cycle gap", c6 - c5, 842);

    // R8: zero parameters act as one tick
    chk(u1_seen > 0 && u1_bad == 0, "R8 one-tick floor", u1_bad, 0);
    // R4: no strobe during a wait
    chk(overlap == 0, "R4 strobe during wait", overlap, 0);

    if (cyc >= WD_LIMIT) chk(1'b0, "watchdog", cyc, WD_LIMIT);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule